// File: doc/BRIEF.md
# Masked Counter Quota Monitor

This block watches a bank of event counter values and raises an interrupt once their combined consumption goes above a programmable limit. A per-counter select mask decides which counters count toward the total. Every cycle the block adds up the selected counter values in an accumulator that cannot wrap. It compares that total with the limit and latches an interrupt flag when the total is strictly larger.

The counter values, the mask and the limit are plain inputs, driven by whatever register wrapper surrounds the block. The latched flag survives later changes to the mask, the limit or the counter values. Only the synchronous clear input or the active-low hardware reset removes it. The enable input gates both the setting of the flag and the visible interrupt line.

Top module: `quota_watch`

## Requirements
- R1: The consumed total is the sum of the values of those counters whose select bit is 1. Counter k occupies bits [k*CTR_W +: CTR_W] of `ctr_val_i`, and select bit k belongs to counter k. Unselected counters have no effect on the interrupt.
- R2: The flag is set only when the total is strictly greater than `limit_i`. A total equal to the limit leaves `irq_o` low.
- R3: The flag is a register. A qualifying input pattern present before a rising clock edge shows on `irq_o` after that edge.
- R4: Once set, the flag stays set even if the mask, the limit or the counter values change so that the total no longer exceeds the limit.
- R5: `clear_i` high at a rising edge clears the flag. It takes priority over a qualifying total in the same cycle.
- R6: While `rst_ni` is low, `irq_o` is low.
- R7: While `enable_i` is low, `irq_o` is low and the flag cannot be set. A flag set before the block was disabled shows again when it is re-enabled.
- R8: The total is built without wrap-around. With all counters selected at their maximum value, the total exceeds a limit of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the interrupt flag |
| enable_i | input | 1 | Enables flag setting and the interrupt output |
| ctr_val_i | input | NUM_CTR*CTR_W | Packed counter values, counter k at bits [k*CTR_W +: CTR_W] |
| sel_mask_i | input | NUM_CTR | Select bit per counter |
| limit_i | input | CTR_W | Quota limit |
| irq_o | output | 1 | Quota interrupt |

## Verification
The hardest situation to reach is a carry out of the counter width. The accumulator only shows it is wide enough when the sum of several full-scale counters passes the limit's width. A narrow adder would fold that sum back below the limit. A second instance at the default width is therefore driven with every counter at all ones against an all-ones limit, and then with a single counter exactly equal to the limit. A reduced instance with four 4-bit counters is swept over every mask and every limit with several value patterns, and each total is computed arithmetically in the bench.

// File: rtl/quota_watch.sv
module quota_watch #(
  parameter int NUM_CTR = 9,
  parameter int CTR_W   = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       enable_i,
  input  logic [NUM_CTR*CTR_W-1:0]   ctr_val_i,
  input  logic [NUM_CTR-1:0]         sel_mask_i,
  input  logic [CTR_W-1:0]           limit_i,
  output logic                       irq_o
);

  localparam int SUM_W = CTR_W + $clog2(NUM_CTR) + 1;

  logic [SUM_W-1:0] used_sum;
  logic             over_limit;
  logic             flag_q;

  always_comb begin
    used_sum = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (sel_mask_i[k]) used_sum = used_sum + SUM_W'(ctr_val_i[k*CTR_W +: CTR_W]);
    end
  end

  assign over_limit = used_sum > SUM_W'(limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (clear_i)                flag_q <= 1'b0;
    else if (enable_i && over_limit) flag_q <= 1'b1;
  end

  assign irq_o = flag_q & enable_i;

  // R3
  set_on_excess_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && over_limit && !clear_i) |=> flag_q);

  // R4
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clear_i) |=> flag_q);

  // R5
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !flag_q);

  // R7
  no_set_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !flag_q) |=> !flag_q);

  // R2
  rise_needs_excess_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(over_limit && enable_i));

endmodule

// File: tb/test_quota_watch.sv
`timescale 1ns/1ps
module test_quota_watch;
  localparam int SN = 4;
  localparam int SW = 4;
  localparam int WN = 9;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              s_clear = 1'b0, s_en = 1'b0;
  logic [SN*SW-1:0]  s_vals = '0;
  logic [SN-1:0]     s_mask = '0;
  logic [SW-1:0]     s_lim = '0;
  logic              s_irq;

  logic              w_clear = 1'b0, w_en = 1'b0;
  logic [WN*WW-1:0]  w_vals = '0;
  logic [WN-1:0]     w_mask = '0;
  logic [WW-1:0]     w_lim = '0;
  logic              w_irq;

  quota_watch #(.NUM_CTR(SN), .CTR_W(SW)) i_quota_watch (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(s_clear), .enable_i(s_en),
    .ctr_val_i(s_vals), .sel_mask_i(s_mask), .limit_i(s_lim), .irq_o(s_irq));

  quota_watch #(.NUM_CTR(WN), .CTR_W(WW)) i_quota_watch_wide (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(w_clear), .enable_i(w_en),
    .ctr_val_i(w_vals), .sel_mask_i(w_mask), .limit_i(w_lim), .irq_o(w_irq));

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", req, got, exp);
    end
  endtask

  task automatic small_case(input int mask, input int lim, input int pat);
    int sum;
    @(negedge clk); s_clear = 1'b1;
    @(negedge clk); s_clear = 1'b0;
    sum = 0;
    for (int k = 0; k < SN; k++) begin
      int v;
      v = (pat * 5 + k * 3 + mask + lim * pat) % 16;
      s_vals[k*SW +: SW] = SW'(v);
      if (mask[k]) sum += v;
    end
    s_mask = SN'(mask);
    s_lim = SW'(lim);
    @(negedge clk);
    // R1 R2 R3: registered strict compare of the masked sum
    chk(s_irq, sum > lim, "R1/R2");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R6: reset state
    s_en = 1'b1; s_vals = '1; s_mask = '1; s_lim = '0;
    repeat (3) @(negedge clk);
    chk(s_irq, 1'b0, "R6");
    rst_n = 1'b1;
    // R3: flag appears one edge after the qualifying pattern
    @(negedge clk);
    chk(s_irq, 1'b1, "R3");

    // R1 R2: sweep all masks and limits over several value patterns
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 16; m++)
        for (int l = 0; l < 16; l++)
          small_case(m, l, p);

    // R2: total exactly equal to the limit
    @(negedge clk); s_clear = 1'b1;
    @(negedge clk); s_clear = 1'b0;
    s_vals = {4'd3, 4'd0, 4'd5, 4'd2}; s_mask = 4'b1011; s_lim = 4'd10;
    @(negedge clk);
    chk(s_irq, 1'b0, "R2 equal");
    s_lim = 4'd9;
    @(negedge clk);
    chk(s_irq, 1'b1, "R2 above");

    // R4: sticky despite mask, limit and value changes
    s_mask = '0; s_lim = '1; s_vals = '0;
    repeat (3) @(negedge clk);
    chk(s_irq, 1'b1, "R4");

    // R5: clear wins over a qualifying total
    s_mask = '1; s_vals = '1; s_lim = '0; s_clear = 1'b1;
    @(negedge clk);
    chk(s_irq, 1'b0, "R5");
    s_clear = 1'b0;
    @(negedge clk);
    chk(s_irq, 1'b1, "R5 release");

    // R7: disabled hides flag, re-enable shows it again
    s_en = 1'b0;
    #0.5;
    chk(s_irq, 1'b0, "R7 hidden");
    s_en = 1'b1;
    #0.5;
    chk(s_irq, 1'b1, "R7 kept");
    // R7: no set while disabled
    @(negedge clk); s_clear = 1'b1;
    @(negedge clk); s_clear = 1'b0; s_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(s_irq, 1'b0, "R7 idle");
    s_vals = '0;
    s_en = 1'b1;
    #0.5;
    chk(s_irq, 1'b0, "R7 not set");

    // R8: no wrap in the wide default instance
    @(negedge clk);
    w_en = 1'b1; w_vals = '1; w_mask = '1; w_lim = '1;
    @(negedge clk);
    chk(w_irq, 1'b1, "R8");
    @(negedge clk); w_clear = 1'b1;
    @(negedge clk); w_clear = 1'b0;
    w_vals = '0; w_vals[5*WW +: WW] = '1; w_mask = 9'h020;
    @(negedge clk);
    chk(w_irq, 1'b0, "R2 wide equal");
    w_vals[0 +: WW] = 32'd1; w_mask = 9'h020;
    @(negedge clk);
    chk(w_irq, 1'b0, "R1 unselected");
    w_mask = 9'h021;
    @(negedge clk);
    chk(w_irq, 1'b1, "R1 selected");

    // R6: reset mid-run clears the flag
    rst_n = 1'b0;
    #0.5;
    chk(w_irq, 1'b0, "R6 midrun");
    chk(s_irq, 1'b0, "R6 midrun small");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule